// File: doc/BRIEF.md
# Streaming Online-Softmax Row Engine

This block turns a batch of 32-bit attention score rows, already sitting in an accumulator memory, into 8-bit softmax weights in a scratchpad memory. One command starts the whole batch, whatever the row count or row length. The block walks the rows in order and handles each row in two passes over 16-wide chunks, one chunk per cycle in each pass.

In the first pass the block keeps a running maximum and a running sum of exponentials. When a chunk raises the maximum, the block scales the old sum down by the exponential of the difference before it adds the new terms. This means a row never has to be held in full. In the second pass the block reads the same chunks again, subtracts the final row maximum, and runs 16 exponential lanes in parallel. It multiplies each lane result by a reciprocal of the row sum, clamps it, and writes the 16 bytes as one scratchpad word.

A host decodes its own command format and drives the command inputs. The two memories sit outside the block, connected through a read port and a write port.

Top module: `oa_softmax_engine`

## Requirements
- R1: While reset is held, and at any time the engine is idle, `busy`, `done`, `acc_rd_en` and `sp_wr_en` are all low.
- R2: `cmd_rows_m1` and `cmd_chunks_m1` carry the row count and the chunks-per-row count minus one, so a value of 0 means one. A command is taken only on a cycle where `cmd_valid` is high and the engine is idle. A command presented while `busy` is high is dropped and writes nothing.
- R3: Row r, chunk c is read from `cmd_src + r*C + c` and written to `cmd_dst + r*C + c`, where C is the chunks-per-row count. Every chunk of the batch is written exactly once and nothing else is written. Within a row, back-to-back accepted writes have consecutive addresses.
- R4: The exponential of a non-negative distance z is 0 when z ≥ 32. Otherwise it is B[z mod 4] shifted right by floor(z/4), with B = {32768, 27520, 23168, 19456}. This gives 2^(-z/4) in Q15.
- R5: For each row, the running max starts at the most negative 32-bit value and the sum starts at 0. For each chunk, new_max = max(running max, largest signed lane score) and sum = floor(sum * exp(new_max - old_max) / 2^15) + Σ exp(new_max - score). When the max does not rise, this reduces to simply adding the new terms.
- R6: After the first pass, recip = floor(2^31 / sum). Each weight is min(floor(exp(final_max - score) * recip / 2^24), 127). Lane i occupies bits [8i+7:8i] of the write word, and lane i takes bits [32i+31:32i] of the read word.
- R7: Scores 32 or more below the row max give a weight of 0, and this includes the full-range extremes of the 32-bit score.
- R8: Read data arrives one cycle after `acc_rd_en` and stays valid until the next read. While `sp_wr_en` is high and `sp_wr_ready` is low, the write address and data stay constant.
- R9: `done` is high for exactly one cycle after the last accepted write. In that cycle `busy` is still high, and it drops in the next cycle.
- R10: With `sp_wr_ready` held high, `done` rises N*(2C+3) cycles after the command is accepted, for N rows of C chunks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_rows_m1 | input | RCW | Row count minus one |
| cmd_chunks_m1 | input | CCW | Chunks per row minus one |
| cmd_src | input | AW | Accumulator address of the first chunk |
| cmd_dst | input | AW | Scratchpad address of the first chunk |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_rd_en | output | 1 | Accumulator read request |
| acc_rd_addr | output | AW | Accumulator read address |
| acc_rd_data | input | LANES*SW | Accumulator read data, one cycle after request |
| sp_wr_en | output | 1 | Scratchpad write valid |
| sp_wr_addr | output | AW | Scratchpad write address |
| sp_wr_data | output | LANES*8 | Packed weights |
| sp_wr_ready | input | 1 | Scratchpad accepts the write |

## Verification
A chunk of 16 equal scores pins the normalization to a hand-computed weight of 8. A single hot lane against minimum-value lanes shows the clamp at 127 and the saturation to zero together. A one-chunk ramp with distances 0, 2, ..., 30 traces the exponential curve. Rows whose chunk maxima climb, and rows whose maxima fall, separate the rescale path from the plain add path. Random batches with random write back-pressure and a sprinkling of extreme values test addressing, stall hold and count, and a command injected while busy tests that it is dropped.

// File: rtl/oa_pkg.sv
package oa_pkg;
   localparam int unsigned EXP_W     = 16;   // Q15 exponent result width
   localparam int unsigned EXP_FRAC  = 15;
   localparam int unsigned SUMW      = 32;   // running sum width
   localparam int unsigned RECIP_W   = 17;   // 2^31 / sum, sum >= 2^15
   localparam int unsigned WGT_SHIFT = 24;
   localparam int unsigned WGT_MAX   = 127;
   localparam int unsigned WW        = 8;    // weight byte width

   typedef enum logic [2:0] {
      ST_IDLE, ST_RD_UPD, ST_UPD, ST_FIN_UPD, ST_RD_WGT, ST_WR_WGT, ST_DONE
   } oa_state_e;
endpackage

// File: rtl/oa_exp_lane.sv
// Base-2 fixed-point exponential of a non-negative distance: 2^(-z/4) in Q15.
module oa_exp_lane
   import oa_pkg::*;
#(
   parameter int unsigned ZW = 33
)(
   input  logic [ZW-1:0]    z,
   output logic [EXP_W-1:0] e
);
   if (ZW < 6) begin : g_bad_zw
      $error("oa_exp_lane: distance width too small");
   end

   logic [EXP_W-1:0] base;

   always_comb begin
      unique case (z[1:0])
         2'd0:    base = 16'd32768;
         2'd1:    base = 16'd27520;
         2'd2:    base = 16'd23168;
         default: base = 16'd19456;
      endcase
      if (|z[ZW-1:5]) e = '0;
      else            e = base >> z[4:2];
   end
endmodule

// File: rtl/oa_chunk_stats.sv
// One chunk of the first pass: lane max, raised max, carry factor, exp sum.
module oa_chunk_stats
   import oa_pkg::*;
#(
   parameter int unsigned LANES = 16,
   parameter int unsigned SW    = 32
)(
   input  logic [LANES*SW-1:0] scores,
   input  logic signed [SW-1:0] run_max,
   output logic signed [SW-1:0] new_max,
   output logic [EXP_W-1:0]    carry_scale,
   output logic [SUMW-1:0]     chunk_sum
);
   logic signed [SW-1:0] chunk_max;
   logic [EXP_W-1:0]     lane_e [LANES];
   logic [SW:0]          carry_z;

   always_comb begin
      chunk_max = scores[SW-1:0];
      for (int i = 1; i < LANES; i++) begin
         if ($signed(scores[i*SW +: SW]) > chunk_max) chunk_max = scores[i*SW +: SW];
      end
   end

   assign new_max = (chunk_max > run_max) ? chunk_max : run_max;
   assign carry_z = {new_max[SW-1], new_max} - {run_max[SW-1], run_max};

   oa_exp_lane #(.ZW(SW+1)) u_carry (.z(carry_z), .e(carry_scale));

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [SW:0] z;
      assign z = {new_max[SW-1], new_max} - {scores[g*SW+SW-1], scores[g*SW +: SW]};
      oa_exp_lane #(.ZW(SW+1)) u_exp (.z(z), .e(lane_e[g]));
   end

   always_comb begin
      chunk_sum = '0;
      for (int i = 0; i < LANES; i++) chunk_sum = chunk_sum + SUMW'(lane_e[i]);
   end
endmodule

// File: rtl/oa_weight_pack.sv
// Second pass: per-lane exp against the final max, scale by reciprocal, clamp, pack.
module oa_weight_pack
   import oa_pkg::*;
#(
   parameter int unsigned LANES = 16,
   parameter int unsigned SW    = 32
)(
   input  logic [LANES*SW-1:0]  scores,
   input  logic signed [SW-1:0] row_max,
   input  logic [RECIP_W-1:0]   recip,
   output logic [LANES*WW-1:0]  weights
);
   localparam int unsigned PW = EXP_W + RECIP_W;
   localparam int unsigned HW = PW - WGT_SHIFT;

   if (HW <= WW) begin : g_bad_hw
      $error("oa_weight_pack: product too narrow for clamp");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [SW:0]      z;
      logic [EXP_W-1:0] e;
      logic [HW-1:0]    hi;
      assign z  = {row_max[SW-1], row_max} - {scores[g*SW+SW-1], scores[g*SW +: SW]};
      oa_exp_lane #(.ZW(SW+1)) u_exp (.z(z), .e(e));
      assign hi = HW'((PW'(e) * PW'(recip)) >> WGT_SHIFT);
      assign weights[g*WW +: WW] = (hi > HW'(WGT_MAX)) ? WW'(WGT_MAX) : hi[WW-1:0];
   end
endmodule

// File: rtl/oa_softmax_engine.sv
module oa_softmax_engine
   import oa_pkg::*;
#(
   parameter int unsigned LANES      = 16,
   parameter int unsigned SW         = 32,
   parameter int unsigned AW         = 16,
   parameter int unsigned MAX_ROWS   = 256,
   parameter int unsigned MAX_CHUNKS = 64,
   localparam int unsigned RCW = $clog2(MAX_ROWS),
   localparam int unsigned CCW = $clog2(MAX_CHUNKS)
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   input  logic [RCW-1:0]      cmd_rows_m1,
   input  logic [CCW-1:0]      cmd_chunks_m1,
   input  logic [AW-1:0]       cmd_src,
   input  logic [AW-1:0]       cmd_dst,
   output logic                busy,
   output logic                done,
   output logic                acc_rd_en,
   output logic [AW-1:0]       acc_rd_addr,
   input  logic [LANES*SW-1:0] acc_rd_data,
   output logic                sp_wr_en,
   output logic [AW-1:0]       sp_wr_addr,
   output logic [LANES*WW-1:0] sp_wr_data,
   input  logic                sp_wr_ready
);
   if (SW < 8 || SW > 32) begin : g_bad_sw
      $error("oa_softmax_engine: score width must be 8..32");
   end
   if (MAX_ROWS < 2 || MAX_CHUNKS < 2) begin : g_bad_cnt
      $error("oa_softmax_engine: row and chunk limits must be at least 2");
   end
   if (AW < RCW + CCW + 1) begin : g_bad_aw
      $error("oa_softmax_engine: address too narrow for a full batch");
   end
   if (EXP_W + CCW + $clog2(LANES) >= SUMW) begin : g_bad_sum
      $error("oa_softmax_engine: running sum could overflow");
   end

   localparam logic signed [SW-1:0] NEG_INF = {1'b1, {(SW-1){1'b0}}};

   oa_state_e            state;
   logic [RCW-1:0]       rows_m1, row_cnt;
   logic [CCW-1:0]       chunks_m1, cur_idx;
   logic [AW-1:0]        row_src, row_dst, row_step;
   logic signed [SW-1:0] run_max, new_max;
   logic [SUMW-1:0]      sum_r, sum_next, chunk_sum;
   logic [EXP_W-1:0]     carry_scale;
   logic [RECIP_W-1:0]   recip_r, recip_d;
   logic [CCW:0]         nxt_idx, rd_off;
   logic                 last_chunk, last_row;

   assign last_chunk = (cur_idx == chunks_m1);
   assign last_row   = (row_cnt == rows_m1);
   assign nxt_idx    = {1'b0, cur_idx} + (CCW+1)'(1);
   assign row_step   = AW'({1'b0, chunks_m1} + (CCW+1)'(1));

   oa_chunk_stats #(.LANES(LANES), .SW(SW)) u_stats (
      .scores(acc_rd_data), .run_max(run_max), .new_max(new_max),
      .carry_scale(carry_scale), .chunk_sum(chunk_sum)
   );

   oa_weight_pack #(.LANES(LANES), .SW(SW)) u_pack (
      .scores(acc_rd_data), .row_max(run_max), .recip(recip_r), .weights(sp_wr_data)
   );

   // Rescaled carry plus this chunk's terms; a zero distance keeps the sum exact.
   assign sum_next = SUMW'(((SUMW+EXP_W)'(sum_r) * (SUMW+EXP_W)'(carry_scale)) >> EXP_FRAC)
                   + chunk_sum;
   assign recip_d  = (sum_r == '0) ? '1 : RECIP_W'(32'h8000_0000 / sum_r);

   always_comb begin
      acc_rd_en = 1'b0;
      rd_off    = '0;
      unique case (state)
         ST_RD_UPD, ST_RD_WGT: acc_rd_en = 1'b1;
         ST_UPD: begin
            acc_rd_en = !last_chunk;
            rd_off    = nxt_idx;
         end
         ST_WR_WGT: begin
            acc_rd_en = sp_wr_ready && !last_chunk;
            rd_off    = nxt_idx;
         end
         default: ;
      endcase
   end

   assign acc_rd_addr = row_src + AW'(rd_off);
   assign sp_wr_addr  = row_dst + AW'(cur_idx);
   assign sp_wr_en    = (state == ST_WR_WGT);
   assign busy        = (state != ST_IDLE);
   assign done        = (state == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         rows_m1   <= '0;
         chunks_m1 <= '0;
         row_cnt   <= '0;
         cur_idx   <= '0;
         row_src   <= '0;
         row_dst   <= '0;
         run_max   <= NEG_INF;
         sum_r     <= '0;
         recip_r   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (cmd_valid) begin
               rows_m1   <= cmd_rows_m1;
               chunks_m1 <= cmd_chunks_m1;
               row_src   <= cmd_src;
               row_dst   <= cmd_dst;
               row_cnt   <= '0;
               state     <= ST_RD_UPD;
            end
            ST_RD_UPD: begin
               run_max <= NEG_INF;
               sum_r   <= '0;
               cur_idx <= '0;
               state   <= ST_UPD;
            end
            ST_UPD: begin
               run_max <= new_max;
               sum_r   <= sum_next;
               if (last_chunk) state <= ST_FIN_UPD;
               else            cur_idx <= cur_idx + CCW'(1);
            end
            ST_FIN_UPD: begin
               recip_r <= recip_d;
               state   <= ST_RD_WGT;
            end
            ST_RD_WGT: begin
               cur_idx <= '0;
               state   <= ST_WR_WGT;
            end
            ST_WR_WGT: if (sp_wr_ready) begin
               if (!last_chunk) begin
                  cur_idx <= cur_idx + CCW'(1);
               end else if (last_row) begin
                  state <= ST_DONE;
               end else begin
                  row_cnt <= row_cnt + RCW'(1);
                  row_src <= row_src + row_step;
                  row_dst <= row_dst + row_step;
                  state   <= ST_RD_UPD;
               end
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/oa_softmax_engine_chk.sv
module oa_softmax_engine_chk
   import oa_pkg::*;
#(
   parameter int unsigned LANES = 16,
   parameter int unsigned AW    = 16
)(
   input logic                clk,
   input logic                rst_n,
   input logic                busy,
   input logic                done,
   input logic                acc_rd_en,
   input logic                sp_wr_en,
   input logic                sp_wr_ready,
   input logic [AW-1:0]       sp_wr_addr,
   input logic [LANES*WW-1:0] sp_wr_data
);
   logic [LANES-1:0] byte_msb;
   for (genvar g = 0; g < LANES; g++) begin : g_msb
      assign byte_msb[g] = sp_wr_data[g*WW + WW - 1];
   end

   // R1: an idle engine issues nothing
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!acc_rd_en && !sp_wr_en && !done));

   // R8: a stalled write holds address and data
   p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_wr_en && !sp_wr_ready) |=> (sp_wr_en && $stable(sp_wr_addr) && $stable(sp_wr_data)));

   // R3: back-to-back accepted writes step the address by one
   p_wr_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_wr_en && sp_wr_ready) |=> (!sp_wr_en || sp_wr_addr == $past(sp_wr_addr) + AW'(1)));

   // R9: done is a single-cycle pulse followed by idle
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R6: every packed weight stays within 0..127
   p_weight_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sp_wr_en |-> (byte_msb == '0));
endmodule

bind oa_softmax_engine oa_softmax_engine_chk #(.LANES(LANES), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .acc_rd_en(acc_rd_en),
   .sp_wr_en(sp_wr_en), .sp_wr_ready(sp_wr_ready), .sp_wr_addr(sp_wr_addr),
   .sp_wr_data(sp_wr_data)
);

// File: tb/oa_softmax_engine_tb_top.sv
module oa_softmax_engine_tb_top;
   localparam int LANES = 16, SW = 32, AW = 16, MAX_ROWS = 256, MAX_CHUNKS = 64;
   localparam int RCW = $clog2(MAX_ROWS), CCW = $clog2(MAX_CHUNKS);
   localparam int DEPTH = 4096;
   localparam logic [LANES*8-1:0] MARK = {LANES{8'hAA}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [RCW-1:0] cmd_rows_m1 = '0;
   logic [CCW-1:0] cmd_chunks_m1 = '0;
   logic [AW-1:0] cmd_src = '0, cmd_dst = '0;
   logic busy, done, acc_rd_en, sp_wr_en;
   logic [AW-1:0] acc_rd_addr, sp_wr_addr;
   logic [LANES*SW-1:0] acc_rd_data = '0;
   logic [LANES*8-1:0] sp_wr_data;
   logic sp_wr_ready = 1'b1;

   always #10 clk = ~clk;   // 50 MHz

   oa_softmax_engine #(.LANES(LANES), .SW(SW), .AW(AW), .MAX_ROWS(MAX_ROWS),
                       .MAX_CHUNKS(MAX_CHUNKS)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rows_m1(cmd_rows_m1),
      .cmd_chunks_m1(cmd_chunks_m1), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
      .busy(busy), .done(done), .acc_rd_en(acc_rd_en), .acc_rd_addr(acc_rd_addr),
      .acc_rd_data(acc_rd_data), .sp_wr_en(sp_wr_en), .sp_wr_addr(sp_wr_addr),
      .sp_wr_data(sp_wr_data), .sp_wr_ready(sp_wr_ready)
   );

   logic [LANES*SW-1:0] acc_mem [0:DEPTH-1];
   logic [LANES*8-1:0]  sp_mem  [0:DEPTH-1];
   int n_chk = 0, n_bad = 0, wr_count = 0, done_count = 0;
   bit rdy_rand = 1'b0;

   // memory models: one-cycle read, handshake write
   always @(posedge clk) begin
      if (acc_rd_en) acc_rd_data <= acc_mem[acc_rd_addr[11:0]];
      if (sp_wr_en && sp_wr_ready) begin
         sp_mem[sp_wr_addr[11:0]] <= sp_wr_data;
         wr_count <= wr_count + 1;
      end
      if (done) done_count <= done_count + 1;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   // ready driver, changes just after the rising edge
   initial forever begin
      @(posedge clk);
      #2 sp_wr_ready = rdy_rand ? ($urandom_range(0, 2) != 0) : 1'b1;
   end

   // R8: stalled write must hold
   initial begin
      bit pend = 1'b0;
      logic [AW-1:0] pa;
      logic [LANES*8-1:0] pd;
      forever begin
         @(negedge clk);
         if (pend) chk(sp_wr_en && sp_wr_addr == pa && sp_wr_data == pd,
                       "R8 stalled write held", longint'(sp_wr_addr), longint'(pa));
         pend = rst_n && sp_wr_en && !sp_wr_ready;
         pa = sp_wr_addr;
         pd = sp_wr_data;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   // ---------------- reference model (from requirements) ----------------
   function automatic longint m_exp(input longint z);
      longint b;
      if (z >= 32) return 0;
      case (z % 4)
         0: b = 32768;
         1: b = 27520;
         2: b = 23168;
         default: b = 19456;
      endcase
      return b >>> (z / 4);
   endfunction

   function automatic longint sc(input int a, input int l);
      return longint'($signed(acc_mem[a][l*SW +: SW]));
   endfunction

   task automatic expect_batch(input int rows, input int ch, input int src, input int dst,
                               input string req);
      for (int r = 0; r < rows; r++) begin
         longint mx = -(64'sd1 <<< 31);
         longint sm = 0;
         longint rc;
         for (int c = 0; c < ch; c++) begin
            int a = src + r*ch + c;
            longint cm = sc(a, 0);
            longint nm;
            for (int l = 1; l < LANES; l++) if (sc(a, l) > cm) cm = sc(a, l);
            nm = (cm > mx) ? cm : mx;
            sm = (sm * m_exp(nm - mx)) >>> 15;
            for (int l = 0; l < LANES; l++) sm += m_exp(nm - sc(a, l));
            mx = nm;
         end
         rc = (sm == 0) ? 131071 : (64'sd1 <<< 31) / sm;
         for (int c = 0; c < ch; c++) begin
            int a = src + r*ch + c;
            int d = dst + r*ch + c;
            logic [LANES*8-1:0] ew;
            int bad_l = -1;
            for (int l = 0; l < LANES; l++) begin
               longint w = (m_exp(mx - sc(a, l)) * rc) >>> 24;
               if (w > 127) w = 127;
               ew[l*8 +: 8] = 8'(w);
            end
            for (int l = LANES-1; l >= 0; l--) if (ew[l*8 +: 8] != sp_mem[d][l*8 +: 8]) bad_l = l;
            if (bad_l < 0) chk(1'b1, req, 0, 0);
            else chk(1'b0, req, longint'(sp_mem[d][bad_l*8 +: 8]), longint'(ew[bad_l*8 +: 8]));
         end
      end
   endtask

   // ---------------- stimulus helpers ----------------
   task automatic clear_sp(input int dst, input int n);
      for (int i = 0; i < n; i++) sp_mem[(dst + i) % DEPTH] = MARK;
   endtask

   task automatic fill_rand(input int a0, input int n, input int span, input bit extreme);
      for (int a = a0; a < a0 + n; a++)
         for (int l = 0; l < LANES; l++) begin
            int v = int'($urandom_range(0, span)) - span/2;
            if (extreme && $urandom_range(0, 5) == 0)
               v = ($urandom_range(0, 1) != 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
            acc_mem[a][l*SW +: SW] = v;
         end
   endtask

   task automatic run_cmd(input int rows, input int ch, input int src, input int dst,
                          input int inj, output int cyc);
      @(negedge clk);
      cmd_rows_m1 = RCW'(rows - 1);
      cmd_chunks_m1 = CCW'(ch - 1);
      cmd_src = AW'(src);
      cmd_dst = AW'(dst);
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      cyc = 0;
      while (!done && cyc < 100000) begin
         cyc++;
         if (cyc == inj) begin
            cmd_dst = AW'(3000);
            cmd_src = AW'(0);
            cmd_valid = 1'b1;
         end else cmd_valid = 1'b0;
         @(negedge clk);
      end
      cmd_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      int cyc, w0, d0;
      void'($urandom(32'd24680));
      for (int i = 0; i < DEPTH; i++) begin
         acc_mem[i] = '0;
         sp_mem[i] = MARK;
      end
      repeat (3) @(negedge clk);
      chk(!busy && !done && !acc_rd_en && !sp_wr_en, "R1 quiet in reset",
          longint'({busy, done, acc_rd_en, sp_wr_en}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done, "R1 idle after reset", longint'({busy, done}), 0);

      // R6: sixteen equal scores -> sum 2^19, recip 4096, weight 8
      for (int l = 0; l < LANES; l++) acc_mem[0][l*SW +: SW] = 32'd5;
      run_cmd(1, 1, 0, 2048, -1, cyc);
      chk(sp_mem[2048] == {LANES{8'd8}}, "R6 uniform chunk", longint'(sp_mem[2048][7:0]), 8);
      chk(cyc == 5, "R10 one row one chunk latency", cyc, 5);
      chk(!busy, "R9 busy drops after done", longint'(busy), 0);

      // R7/R6: one hot lane against extreme negatives
      for (int l = 0; l < LANES; l++) acc_mem[1][l*SW +: SW] = 32'h8000_0000;
      acc_mem[1][3*SW +: SW] = 32'd100;
      run_cmd(1, 1, 1, 2049, -1, cyc);
      chk(sp_mem[2049][3*8 +: 8] == 8'd127, "R6 clamp at 127", longint'(sp_mem[2049][3*8 +: 8]), 127);
      chk((sp_mem[2049] & ~({LANES*8{1'b0}} | (128'hFF << 24))) == '0, "R7 far lanes zero",
          longint'(sp_mem[2049][7:0]), 0);

      // R4: ramp with distances 0,2,...,30
      for (int l = 0; l < LANES; l++) acc_mem[2][l*SW +: SW] = 100 - 2*l;
      run_cmd(1, 1, 2, 2050, -1, cyc);
      expect_batch(1, 1, 2, 2050, "R4 exponential curve");

      // R5: rising chunk maxima (rescale) and falling maxima (plain add)
      for (int c = 0; c < 6; c++)
         for (int l = 0; l < LANES; l++) begin
            acc_mem[10 + c][l*SW +: SW] = c*5 + l;
            acc_mem[20 + c][l*SW +: SW] = 50 - c*5 - l;
         end
      run_cmd(1, 6, 10, 2100, -1, cyc);
      expect_batch(1, 6, 10, 2100, "R5 rising max rescale");
      run_cmd(1, 6, 20, 2110, -1, cyc);
      expect_batch(1, 6, 20, 2110, "R5 falling max add");

      // R10/R3: multi-row batch, ready held high
      fill_rand(100, 12, 60, 1'b0);
      clear_sp(2200, 14);
      w0 = wr_count;
      run_cmd(3, 4, 100, 2200, -1, cyc);
      chk(cyc == 33, "R10 three rows four chunks", cyc, 33);
      chk(wr_count - w0 == 12, "R3 write count", wr_count - w0, 12);
      chk(sp_mem[2212] == MARK, "R3 no write past batch", longint'(sp_mem[2212][7:0]), 'hAA);
      expect_batch(3, 4, 100, 2200, "R3 multi-row weights");

      // random batches with back-pressure
      rdy_rand = 1'b1;
      for (int it = 0; it < 12; it++) begin
         int rows = $urandom_range(1, 5);
         int ch = $urandom_range(1, 8);
         int src = 200 + it*50;
         int dst = 2300 + it*50;
         fill_rand(src, rows*ch, (it % 2 == 0) ? 40 : 90, it % 3 == 2);
         clear_sp(dst, rows*ch + 1);
         w0 = wr_count;
         d0 = done_count;
         run_cmd(rows, ch, src, dst, -1, cyc);
         chk(wr_count - w0 == rows*ch, "R3 random write count", wr_count - w0, rows*ch);
         chk(done_count - d0 == 1, "R9 single done pulse", done_count - d0, 1);
         chk(sp_mem[dst + rows*ch] == MARK, "R3 random region bound",
             longint'(sp_mem[dst + rows*ch][7:0]), 'hAA);
         expect_batch(rows, ch, src, dst, (it % 3 == 2) ? "R7 extremes random" : "R8 random stall");
      end

      // R2: command injected while busy is dropped
      fill_rand(900, 8, 40, 1'b0);
      clear_sp(2900, 9);
      clear_sp(3000, 8);
      w0 = wr_count;
      run_cmd(2, 4, 900, 2900, 6, cyc);
      chk(wr_count - w0 == 8, "R2 busy command adds no writes", wr_count - w0, 8);
      chk(sp_mem[3000] == MARK, "R2 busy command target untouched",
          longint'(sp_mem[3000][7:0]), 'hAA);
      repeat (3) @(negedge clk);
      chk(!busy, "R2 busy command not queued", longint'(busy), 0);
      expect_batch(2, 4, 900, 2900, "R2 original batch intact");

      summary();
      $finish;
   end
endmodule